// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the supervisory logic of a plug-in card's power switch. It receives digital comparator results for the host supplies, the card-side supplies, two auxiliary voltage monitors and the current-sense comparators. It also receives the two board-select inputs, a host power-enable line and a software gate request. From these it decides, on every clock, whether the external supply switches may conduct.

The block drives the switch gate enable and an active-low copy of it for driver status. It also drives an active-low healthy indication and the card reset. The card reset is released only after the card supplies have stayed good for a programmable number of microsecond ticks. An electronic circuit breaker filters each current-sense comparator against a tick counter. A trip latches a fault that turns the switches off. The fault stays latched until power-enable is taken low.

Top module: `hotswap_seq`

## Requirements
- R1: While `rst_n` is low: `gate_en`=0, `drv_on_n`=1, `healthy_n`=1, `fault_n`=1, `card_rst`=1.
- R2: `gate_en` rises, one clock after its conditions are met, only when all of these hold: both `bdsel_n` bits are 0, the host group is valid, no fault is latched, and `pwr_en` or `sw_gate` is 1.
- R3: If either `bdsel_n` bit is 1, then on the next clock `gate_en`=0, `healthy_n`=1 and `card_rst`=1.
- R4: If the host group becomes invalid, then on the next clock `gate_en`=0 and `card_rst`=1.
- R5: If the card group becomes invalid, only these change on the next clock: `healthy_n`=1 and `card_rst`=1. `gate_en` stays 1 while the host group is valid and the breaker is not tripped.
- R6: When any `oc_trip` bit stays 1 across FILT_TICKS+1 consecutive ticks, the breaker trips. On the clock after that tick, `gate_en`=0 and `fault_n`=0.
- R7: A current-sense bit that returns to 0 restarts its own filter count from zero, so a shorter pulse never trips.
- R8: A latched fault clears on the first clock at which `pwr_en` is 0. It persists while `pwr_en` stays 1. After `pwr_en` returns to 1, the gates come on again.
- R9: When `vsel`=1, the host group uses `host3_ok` only. When `vsel`=0, it requires both `host5_ok` and `host3_ok`.
- R10: Each `aux_ok[i]` joins the card group when AUX_CARD_MASK[i]=1, and joins the host group when AUX_CARD_MASK[i]=0. It is ANDed with that group's supplies.
- R11: While `pwr_en`=0, `sw_gate`=1 requests the gates (all other R2 conditions still apply), and `sw_gate`=0 turns them off.
- R12: `drv_on_n` always equals the inverse of `gate_en`.
- R13: `healthy_n` goes 0 on the clock after the gates are on and the card group is valid. `card_rst` goes 0 only after RST_TICKS further ticks with that condition held without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| vsel | input | 1 | Static host-monitor select, 1 = 3.3 V host rail only |
| host5_ok | input | 1 | Host 5 V rail at or above its trip level |
| host3_ok | input | 1 | Host 3.3 V rail at or above its trip level |
| card5_ok | input | 1 | Card 5 V rail at or above its trip level |
| card3_ok | input | 1 | Card 3.3 V rail at or above its trip level |
| aux_ok | input | N_AUX | Auxiliary monitor good status |
| oc_trip | input | N_SENSE | Current-sense comparators, 1 = over threshold |
| bdsel_n | input | 2 | Board-select inputs, active low |
| pwr_en | input | 1 | Host power enable |
| sw_gate | input | 1 | Software gate request, used while pwr_en is low |
| gate_en | output | 1 | Supply switch gate enable |
| drv_on_n | output | 1 | Driver status, low while gates are on |
| healthy_n | output | 1 | Card power healthy, active low |
| fault_n | output | 1 | Latched over-current fault, active low |
| card_rst | output | 1 | Card reset, active high |

## Verification
The hardest condition to reach from the ports is a current-sense pulse that comes within a tick or two of the trip limit. The stimulus first holds a comparator high for fourteen ticks, then drops it for a few clocks, then holds it again for another fourteen ticks. A correct filter does not trip on this pattern, while a filter that keeps its count across the gap does. Only after this does the comparator stay high long enough to trip. The stimulus also clears the latched fault, first holding power-enable high to show the fault persists and then taking it low. In each scenario the reference model predicts the exact clock at which the gate, fault and reset outputs change.

// File: rtl/hs_pkg.sv
package hs_pkg;
   typedef struct packed {
      logic inserted;
      logic host_ok;
      logic card_ok;
   } hs_qual_t;
endpackage

// File: rtl/hs_qual.sv
module hs_qual #(
   parameter int N_AUX = 2,
   parameter logic [N_AUX-1:0] AUX_CARD_MASK = '0
) (
   input  logic             vsel,
   input  logic             host5_ok,
   input  logic             host3_ok,
   input  logic             card5_ok,
   input  logic             card3_ok,
   input  logic [N_AUX-1:0] aux_ok,
   input  logic [1:0]       bdsel_n,
   output hs_pkg::hs_qual_t qual
);
   logic [N_AUX-1:0] aux_host_good;
   logic [N_AUX-1:0] aux_card_good;

   // each auxiliary monitor lands in exactly one group
   for (genvar i = 0; i < N_AUX; i++) begin : g_aux
      if (AUX_CARD_MASK[i]) begin : g_card
         assign aux_card_good[i] = aux_ok[i];
         assign aux_host_good[i] = 1'b1;
      end else begin : g_host
         assign aux_card_good[i] = 1'b1;
         assign aux_host_good[i] = aux_ok[i];
      end
   end

   logic host_rails;
   assign host_rails = vsel ? host3_ok : (host5_ok & host3_ok);

   assign qual.inserted = (bdsel_n == 2'b00);
   assign qual.host_ok  = host_rails & (&aux_host_good);
   assign qual.card_ok  = card5_ok & card3_ok & (&aux_card_good);
endmodule

// File: rtl/hs_breaker.sv
module hs_breaker #(
   parameter int N_SENSE    = 2,
   parameter int FILT_TICKS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_us,
   input  logic [N_SENSE-1:0] oc_trip,
   input  logic               pwr_en,
   output logic               trip_now,
   output logic               fault_q
);
   localparam int CW = $clog2(FILT_TICKS + 1);
   localparam logic [CW-1:0] CMAX = CW'(FILT_TICKS);

   logic [N_SENSE-1:0] ch_trip;

   for (genvar i = 0; i < N_SENSE; i++) begin : g_ch
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (!oc_trip[i])
            cnt_q <= '0;
         else if (tick_us && cnt_q != CMAX)
            cnt_q <= cnt_q + 1'b1;
      end
      assign ch_trip[i] = oc_trip[i] & tick_us & (cnt_q == CMAX);
   end

   assign trip_now = |ch_trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fault_q <= 1'b0;
      else if (trip_now)
         fault_q <= 1'b1;
      else if (!pwr_en)
         fault_q <= 1'b0;
   end
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl #(
   parameter int RST_TICKS = 25000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_us,
   input  hs_pkg::hs_qual_t qual,
   input  logic             pwr_en,
   input  logic             sw_gate,
   input  logic             trip_now,
   input  logic             fault_q,
   output logic             gate_en,
   output logic             drv_on_n,
   output logic             healthy_n,
   output logic             card_rst
);
   localparam int RW = $clog2(RST_TICKS + 1);
   localparam logic [RW-1:0] RMAX = RW'(RST_TICKS);

   logic          gate_d;
   logic          good_d;
   logic [RW-1:0] rcnt_q;

   assign gate_d = qual.inserted & qual.host_ok & (pwr_en | sw_gate)
                 & ~fault_q & ~trip_now;
   assign good_d = gate_d & qual.card_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_en   <= 1'b0;
         drv_on_n  <= 1'b1;
         healthy_n <= 1'b1;
         card_rst  <= 1'b1;
         rcnt_q    <= '0;
      end else begin
         gate_en   <= gate_d;
         drv_on_n  <= ~gate_d;
         healthy_n <= ~good_d;
         card_rst  <= ~(good_d & (rcnt_q == RMAX));
         if (!good_d)
            rcnt_q <= '0;
         else if (tick_us && rcnt_q != RMAX)
            rcnt_q <= rcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
   parameter int N_AUX      = 2,
   parameter int N_SENSE    = 2,
   parameter logic [N_AUX-1:0] AUX_CARD_MASK = '0,
   parameter int FILT_TICKS = 16,
   parameter int RST_TICKS  = 25000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_us,
   input  logic               vsel,
   input  logic               host5_ok,
   input  logic               host3_ok,
   input  logic               card5_ok,
   input  logic               card3_ok,
   input  logic [N_AUX-1:0]   aux_ok,
   input  logic [N_SENSE-1:0] oc_trip,
   input  logic [1:0]         bdsel_n,
   input  logic               pwr_en,
   input  logic               sw_gate,
   output logic               gate_en,
   output logic               drv_on_n,
   output logic               healthy_n,
   output logic               fault_n,
   output logic               card_rst
);
   if (N_AUX < 1) begin : g_bad_aux
      $error("N_AUX must be at least 1");
   end
   if (N_SENSE < 1) begin : g_bad_sense
      $error("N_SENSE must be at least 1");
   end
   if (FILT_TICKS < 1) begin : g_bad_filt
      $error("FILT_TICKS must be at least 1");
   end
   if (RST_TICKS < 1) begin : g_bad_rst
      $error("RST_TICKS must be at least 1");
   end

   hs_pkg::hs_qual_t qual;
   logic             trip_now;
   logic             fault_q;

   hs_qual #(.N_AUX(N_AUX), .AUX_CARD_MASK(AUX_CARD_MASK)) u_qual (
      .vsel     (vsel),
      .host5_ok (host5_ok),
      .host3_ok (host3_ok),
      .card5_ok (card5_ok),
      .card3_ok (card3_ok),
      .aux_ok   (aux_ok),
      .bdsel_n  (bdsel_n),
      .qual     (qual)
   );

   hs_breaker #(.N_SENSE(N_SENSE), .FILT_TICKS(FILT_TICKS)) u_brk (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_us  (tick_us),
      .oc_trip  (oc_trip),
      .pwr_en   (pwr_en),
      .trip_now (trip_now),
      .fault_q  (fault_q)
   );

   hs_ctrl #(.RST_TICKS(RST_TICKS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_us   (tick_us),
      .qual      (qual),
      .pwr_en    (pwr_en),
      .sw_gate   (sw_gate),
      .trip_now  (trip_now),
      .fault_q   (fault_q),
      .gate_en   (gate_en),
      .drv_on_n  (drv_on_n),
      .healthy_n (healthy_n),
      .card_rst  (card_rst)
   );

   assign fault_n = ~fault_q;
endmodule

// File: rtl/hotswap_seq_chk.sv
module hotswap_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       vsel,
   input logic       host5_ok,
   input logic       host3_ok,
   input logic [1:0] bdsel_n,
   input logic       pwr_en,
   input logic       sw_gate,
   input logic       gate_en,
   input logic       drv_on_n,
   input logic       healthy_n,
   input logic       fault_n,
   input logic       card_rst
);
   assert_gate_permit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> $past(bdsel_n == 2'b00 && (pwr_en || sw_gate)));

   assert_removal_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bdsel_n != 2'b00) |=> (!gate_en && healthy_n && card_rst));

   assert_host_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsel ? !host3_ok : !(host5_ok && host3_ok)) |=> (!gate_en && card_rst));

   assert_off_unhealthy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |-> (healthy_n && card_rst));

   assert_fault_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n) |-> !gate_en);

   assert_fault_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_n) |-> $past(!pwr_en));

   assert_drv_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
      drv_on_n == !gate_en);

   assert_rst_after_healthy_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !card_rst |-> !healthy_n);
endmodule

bind hotswap_seq hotswap_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vsel      (vsel),
   .host5_ok  (host5_ok),
   .host3_ok  (host3_ok),
   .bdsel_n   (bdsel_n),
   .pwr_en    (pwr_en),
   .sw_gate   (sw_gate),
   .gate_en   (gate_en),
   .drv_on_n  (drv_on_n),
   .healthy_n (healthy_n),
   .fault_n   (fault_n),
   .card_rst  (card_rst)
);

// File: tb/test_hotswap_seq.sv
`timescale 1ns/1ps
module test_hotswap_seq;
   localparam int FILT = 16;
   localparam int RSTT = 8;
   localparam logic [1:0] MASK = 2'b10;   // aux1 card side, aux0 host side

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b0;
   logic vsel = 1'b0;
   logic host5_ok = 1'b1, host3_ok = 1'b1, card5_ok = 1'b1, card3_ok = 1'b1;
   logic [1:0] aux_ok = 2'b11;
   logic [1:0] oc_trip = 2'b00;
   logic [1:0] bdsel_n = 2'b11;
   logic pwr_en = 1'b0, sw_gate = 1'b0;
   logic gate_en, drv_on_n, healthy_n, fault_n, card_rst;

   always #2.5 clk = ~clk;

   hotswap_seq #(.N_AUX(2), .N_SENSE(2), .AUX_CARD_MASK(MASK),
                 .FILT_TICKS(FILT), .RST_TICKS(RSTT)) i_hotswap_seq (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .vsel(vsel),
      .host5_ok(host5_ok), .host3_ok(host3_ok), .card5_ok(card5_ok),
      .card3_ok(card3_ok), .aux_ok(aux_ok), .oc_trip(oc_trip),
      .bdsel_n(bdsel_n), .pwr_en(pwr_en), .sw_gate(sw_gate),
      .gate_en(gate_en), .drv_on_n(drv_on_n), .healthy_n(healthy_n),
      .fault_n(fault_n), .card_rst(card_rst));

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   task automatic check(input string tag, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference
   int m_cnt [2];
   bit m_fault, m_gate, m_hn, m_rst;
   int m_rcnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt[0] = 0; m_cnt[1] = 0;
         m_fault = 0; m_gate = 0; m_hn = 1; m_rst = 1; m_rcnt = 0;
      end else begin
         bit hv, cv, ins, trip, good;
         hv = vsel ? host3_ok : (host5_ok && host3_ok);
         cv = card5_ok && card3_ok;
         for (int i = 0; i < 2; i++) begin
            if (MASK[i]) cv = cv && aux_ok[i];
            else hv = hv && aux_ok[i];
         end
         ins = (bdsel_n == 2'b00);
         trip = 0;
         for (int i = 0; i < 2; i++) begin
            if (oc_trip[i]) begin
               if (tick_us && m_cnt[i] == FILT) trip = 1;
               if (tick_us && m_cnt[i] < FILT) m_cnt[i]++;
            end else m_cnt[i] = 0;
         end
         m_gate = ins && hv && (pwr_en || sw_gate) && !m_fault && !trip;
         if (trip) m_fault = 1;
         else if (!pwr_en) m_fault = 0;
         good = m_gate && cv;
         m_hn = !good;
         m_rst = !(good && m_rcnt == RSTT);
         if (!good) m_rcnt = 0;
         else if (tick_us && m_rcnt < RSTT) m_rcnt++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 gate_en vs model", gate_en, m_gate);
         check("R12 drv_on_n vs model", drv_on_n, !m_gate);
         check("R5 healthy_n vs model", healthy_n, m_hn);
         check("R6 fault_n vs model", fault_n, !m_fault);
         check("R13 card_rst vs model", card_rst, m_rst);
      end
   end

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
         cyc++;
         tick_us = (cyc % 4 == 0);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      check("R1 gate_en in reset", gate_en, 1'b0);
      check("R1 drv_on_n in reset", drv_on_n, 1'b1);
      check("R1 healthy_n in reset", healthy_n, 1'b1);
      check("R1 fault_n in reset", fault_n, 1'b1);
      check("R1 card_rst in reset", card_rst, 1'b1);
      rst_n = 1'b1;
      step(2);
      // R2: power-enable alone with the board not seated
      pwr_en = 1'b1;
      step(4);
      check("R2 no gate without insertion", gate_en, 1'b0);
      bdsel_n = 2'b10;
      step(4);
      check("R2 no gate with one select", gate_en, 1'b0);
      bdsel_n = 2'b00;
      step(1);
      check("R2 gate on after insertion", gate_en, 1'b1);
      check("R13 healthy_n low with gate", healthy_n, 1'b0);
      check("R13 reset still held", card_rst, 1'b1);
      step(40);
      check("R13 reset released after hold", card_rst, 1'b0);
      // R5: card rail loss
      card3_ok = 1'b0;
      step(1);
      check("R5 gate stays on", gate_en, 1'b1);
      check("R5 healthy_n high", healthy_n, 1'b1);
      check("R5 reset asserted", card_rst, 1'b1);
      card3_ok = 1'b1;
      step(40);
      // R4 and R9
      host5_ok = 1'b0;
      step(1);
      check("R4 gate off on host loss", gate_en, 1'b0);
      check("R4 reset on host loss", card_rst, 1'b1);
      vsel = 1'b1;
      step(2);
      check("R9 3.3V-only host select ignores 5V", gate_en, 1'b1);
      host3_ok = 1'b0;
      step(2);
      check("R9 3.3V rail governs", gate_en, 1'b0);
      host3_ok = 1'b1; host5_ok = 1'b1; vsel = 1'b0;
      step(4);
      // R10: aux0 host side, aux1 card side
      aux_ok = 2'b10;
      step(2);
      check("R10 host-side aux drops gate", gate_en, 1'b0);
      aux_ok = 2'b01;
      step(2);
      check("R10 card-side aux keeps gate", gate_en, 1'b1);
      check("R10 card-side aux clears healthy", healthy_n, 1'b1);
      aux_ok = 2'b11;
      step(40);
      // R7: near-limit pulses with a gap
      oc_trip = 2'b01;
      step(56);
      oc_trip = 2'b00;
      step(3);
      oc_trip = 2'b01;
      step(56);
      check("R7 gapped pulses do not trip", fault_n, 1'b1);
      check("R7 gate still on", gate_en, 1'b1);
      step(20);
      check("R6 sustained trip latches fault", fault_n, 1'b0);
      check("R6 sustained trip opens gate", gate_en, 1'b0);
      oc_trip = 2'b00;
      step(12);
      check("R8 fault persists while enabled", fault_n, 1'b0);
      check("R8 gate held off", gate_en, 1'b0);
      pwr_en = 1'b0;
      step(1);
      check("R8 fault cleared by enable low", fault_n, 1'b1);
      pwr_en = 1'b1;
      step(2);
      check("R8 gate back after re-enable", gate_en, 1'b1);
      // second sense channel
      oc_trip = 2'b10;
      step(80);
      check("R6 second channel trips", fault_n, 1'b0);
      oc_trip = 2'b00;
      pwr_en = 1'b0;
      step(2);
      // R11 software control
      check("R11 off with no request", gate_en, 1'b0);
      sw_gate = 1'b1;
      step(2);
      check("R11 software turns gate on", gate_en, 1'b1);
      check("R12 driver status low", drv_on_n, 1'b0);
      sw_gate = 1'b0;
      step(2);
      check("R11 software turns gate off", gate_en, 1'b0);
      check("R12 driver status high", drv_on_n, 1'b1);
      pwr_en = 1'b1;
      step(40);
      // R3 removal
      bdsel_n = 2'b01;
      step(1);
      check("R3 gate off on removal", gate_en, 1'b0);
      check("R3 healthy_n high on removal", healthy_n, 1'b1);
      check("R3 reset on removal", card_rst, 1'b1);
      step(4);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule